// File: doc/BRIEF.md
# Display Status and Feature-Control Register Pair

This block holds the small group of I/O registers that a legacy color display adapter shows to firmware for probing the display and its attachments. Firmware drives two general-purpose feature-control lines through a write-only port. It then reads two status bytes. The first status byte reports retrace, vertical sync and the light-pen state, together with a diagnostic pair of bits taken from the current pixel's color attribute. The second status byte carries the two sense lines that come back from the feature connector.

A power-on probe drives one feature-control line, reads the sense pair, drives the other line and reads again. Each read must therefore show the sense lines as they are at that moment. Every display-side input is asynchronous to the bus clock. Each one passes through a two-flop synchronizer before any register logic uses it. Read data is registered and shows on the bus one cycle after the read strobe.

Top module: `disp_status_regs`

## Requirements
- R1: A write to address 0 stores data bits 1:0 on `fc_out` (bit 0 drives `fc_out[0]`, bit 1 drives `fc_out[1]`), visible the cycle after the write. The other data bits are ignored. `fc_out` changes on no other write.
- R2: After reset, `fc_out` is 0. Status bits that carry no function read as 1: bits 7:6 of status-1, and bits 7 and 4:0 of status-0.
- R3: Status-1 (read at address 0) bit 0 is 1 when `hblank_in` or `vblank_in` is high, and 0 when both are low.
- R4: Status-1 bit 1 is the light-pen flag. A rising edge of `pen_strobe` sets it. It stays set until a write to address 3 clears it. A write to address 4 forces it to 1.
- R5: If a synchronized rising edge of `pen_strobe` falls in the same cycle as a clearing write to address 3, the flag ends up set.
- R6: Status-1 bit 2 follows `pen_switch_open`: 1 when the switch is open, 0 when it is closed.
- R7: Status-1 bit 3 follows `vsync_in`.
- R8: A write to address 2 stores data bits 5:4 as the diagnostic select. Status-1 bits 5:4 return {pix_attr[2],pix_attr[0]} for select 0, {pix_attr[5],pix_attr[4]} for select 1, {pix_attr[3],pix_attr[1]} for select 2, and {pix_attr[7],pix_attr[6]} for select 3. The select resets to 0.
- R9: Status-0 (read at address 1) bit 5 is `sense_in[0]` and bit 6 is `sense_in[1]`. The value is taken at every read, so a change on the lines shows on the next read.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_rd`, and reflects inputs that have been stable for two clocks. A read at any address above 1 returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| hblank_in | input | 1 | Horizontal retrace from the timing generator |
| vblank_in | input | 1 | Vertical retrace from the timing generator |
| vsync_in | input | 1 | Vertical sync pulse |
| pen_strobe | input | 1 | Light-pen trigger strobe |
| pen_switch_open | input | 1 | Light-pen switch, 1 when open |
| sense_in | input | 2 | Feature-connector sense lines |
| pix_attr | input | 8 | Color attribute bits of the current pixel |
| fc_out | output | 2 | Feature-control outputs |

## Verification
Two functions can act on the light-pen flag in the same cycle: a synchronized strobe edge and a clearing write. The bench lines up the clearing write with the one cycle in which the synchronized edge is detected. It then expects the flag to read 1. In a second run it places the clear one cycle after the edge and expects 0, which shows that the placement is what decides the outcome. A third pairing crosses a feature-control write with a status-0 read, the way the probe does. Each sense value must match the lines as they were at that read, and must not depend on the feature write.

// File: rtl/disp_status_pkg.sv
package disp_status_pkg;

  typedef enum logic [2:0] {
    PORT_STAT1_FEAT = 3'd0,
    PORT_STAT0      = 3'd1,
    PORT_PLANE      = 3'd2,
    PORT_PEN_CLR    = 3'd3,
    PORT_PEN_SET    = 3'd4
  } port_e;

  localparam int unsigned PORT_W = 3;

  // Index of each display input inside the synchronized vector
  localparam int unsigned IX_HBL   = 0;
  localparam int unsigned IX_VBL   = 1;
  localparam int unsigned IX_VSY   = 2;
  localparam int unsigned IX_PSTB  = 3;
  localparam int unsigned IX_PSW   = 4;
  localparam int unsigned IX_SNS   = 5;
  localparam int unsigned SNS_W    = 2;
  localparam int unsigned IX_PIX   = IX_SNS + SNS_W;
  localparam int unsigned PIX_W    = 8;
  localparam int unsigned SYNC_W   = IX_PIX + PIX_W;

  // Diagnostic pair selection: {high, low} pixel bits for each select code
  function automatic logic [1:0] pick_diag(input logic [1:0] sel,
                                           input logic [PIX_W-1:0] pix);
    logic [1:0] r;
    unique case (sel)
      2'd0: r = {pix[2], pix[0]};
      2'd1: r = {pix[5], pix[4]};
      2'd2: r = {pix[3], pix[1]};
      default: r = {pix[7], pix[6]};
    endcase
    return r;
  endfunction

  function automatic logic [7:0] pack_stat1(input logic retrace,
                                            input logic pen_flag,
                                            input logic sw_open,
                                            input logic vsync,
                                            input logic [1:0] diag);
    return {2'b11, diag, vsync, sw_open, pen_flag, retrace};
  endfunction

  function automatic logic [7:0] pack_stat0(input logic [SNS_W-1:0] sense);
    return {1'b1, sense, 5'b11111};
  endfunction

  function automatic logic addr_hit(input logic [PORT_W-1:0] addr,
                                    input port_e port);
    return addr == PORT_W'(port);
  endfunction

endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int i = 1; i < int'(STAGES); i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pen_latch.sv
module pen_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_sync,
  input  logic clr_wr,
  input  logic set_wr,
  output logic pen_rise,
  output logic pen_flag
);

  logic strobe_prev_q;
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_prev_q <= 1'b0;
    else        strobe_prev_q <= strobe_sync;
  end

  assign pen_rise = strobe_sync & ~strobe_prev_q;

  // Setting sources take priority over a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)                   flag_q <= 1'b0;
    else if (pen_rise || set_wr)  flag_q <= 1'b1;
    else if (clr_wr)              flag_q <= 1'b0;
  end

  assign pen_flag = flag_q;

  a_r4_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    pen_rise |=> pen_flag);
  a_r4_set_port: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> pen_flag);
  a_r4_clear_port: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !pen_rise && !set_wr) |=> !pen_flag);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && !pen_rise && !set_wr) |=> $stable(pen_flag));
  a_r5_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pen_rise && clr_wr) |=> pen_flag);

endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import disp_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [1:0]        wd_feat,
  input  logic [1:0]        wd_sel,
  output logic              wr_feat,
  output logic              wr_plane,
  output logic              wr_pen_clr,
  output logic              wr_pen_set,
  output logic [1:0]        fc_q,
  output logic [1:0]        diag_sel_q
);

  logic [PORT_W-1:0] port_addr;
  logic              addr_in_range;

  if (ADDR_W > PORT_W) begin : g_wide
    assign addr_in_range = (bus_addr[ADDR_W-1:PORT_W] == '0);
    assign port_addr     = bus_addr[PORT_W-1:0];
  end else begin : g_narrow
    assign addr_in_range = 1'b1;
    assign port_addr     = PORT_W'(bus_addr);
  end

  assign wr_feat    = bus_wr && addr_in_range && addr_hit(port_addr, PORT_STAT1_FEAT);
  assign wr_plane   = bus_wr && addr_in_range && addr_hit(port_addr, PORT_PLANE);
  assign wr_pen_clr = bus_wr && addr_in_range && addr_hit(port_addr, PORT_PEN_CLR);
  assign wr_pen_set = bus_wr && addr_in_range && addr_hit(port_addr, PORT_PEN_SET);

  always_ff @(posedge clk) begin
    if (!rst_n)       fc_q <= 2'b00;
    else if (wr_feat) fc_q <= wd_feat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        diag_sel_q <= 2'b00;
    else if (wr_plane) diag_sel_q <= wd_sel;
  end

  a_r1_feat_latch: assert property (@(posedge clk) disable iff (!rst_n)
    wr_feat |=> fc_q == $past(wd_feat));
  a_r1_feat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_feat |=> $stable(fc_q));
  a_r8_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_plane |=> $stable(diag_sel_q));
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_feat, wr_plane, wr_pen_clr, wr_pen_set}));

endmodule

// File: rtl/status_read.sv
module status_read
  import disp_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic [7:0]        stat1_val,
  input  logic [7:0]        stat0_val,
  output logic              rd_stat1,
  output logic              rd_stat0,
  output logic [7:0]        rdata_q
);

  logic [7:0] rd_mux;

  assign rd_stat1 = bus_rd && (bus_addr == ADDR_W'(PORT_STAT1_FEAT));
  assign rd_stat0 = bus_rd && (bus_addr == ADDR_W'(PORT_STAT0));

  always_comb begin
    if (rd_stat1)      rd_mux = stat1_val;
    else if (rd_stat0) rd_mux = stat0_val;
    else               rd_mux = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= 8'hFF;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  a_r2_stat0_ones: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat0 |=> (rdata_q[4:0] == 5'h1F) && rdata_q[7]);
  a_r2_stat1_ones: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat1 |=> rdata_q[7:6] == 2'b11);
  a_r10_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !rd_stat0 && !rd_stat1) |=> rdata_q == 8'hFF);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(rdata_q));

endmodule

// File: rtl/disp_status_regs.sv
module disp_status_regs
  import disp_status_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              hblank_in,
  input  logic              vblank_in,
  input  logic              vsync_in,
  input  logic              pen_strobe,
  input  logic              pen_switch_open,
  input  logic [1:0]        sense_in,
  input  logic [7:0]        pix_attr,
  output logic [1:0]        fc_out
);

  logic [SYNC_W-1:0] raw_vec, syn_vec;
  logic wr_feat, wr_plane, wr_pen_clr, wr_pen_set;
  logic rd_stat1, rd_stat0;
  logic pen_rise, pen_flag;
  logic [1:0] diag_sel, diag_pair;
  logic [7:0] stat1_val, stat0_val;
  logic unused_wdata;

  assign unused_wdata = ^{bus_wdata[7:6], bus_wdata[3:2]};

  assign raw_vec = {pix_attr, sense_in, pen_switch_open, pen_strobe,
                    vsync_in, vblank_in, hblank_in};

  sync_bank #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_vec),
    .sync_out (syn_vec)
  );

  ctl_regs #(.ADDR_W(ADDR_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .wd_feat    (bus_wdata[1:0]),
    .wd_sel     (bus_wdata[5:4]),
    .wr_feat    (wr_feat),
    .wr_plane   (wr_plane),
    .wr_pen_clr (wr_pen_clr),
    .wr_pen_set (wr_pen_set),
    .fc_q       (fc_out),
    .diag_sel_q (diag_sel)
  );

  pen_latch u_pen (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_sync (syn_vec[IX_PSTB]),
    .clr_wr      (wr_pen_clr),
    .set_wr      (wr_pen_set),
    .pen_rise    (pen_rise),
    .pen_flag    (pen_flag)
  );

  assign diag_pair = pick_diag(diag_sel, syn_vec[IX_PIX +: PIX_W]);

  assign stat1_val = pack_stat1(syn_vec[IX_HBL] | syn_vec[IX_VBL],
                                pen_flag,
                                syn_vec[IX_PSW],
                                syn_vec[IX_VSY],
                                diag_pair);
  assign stat0_val = pack_stat0(syn_vec[IX_SNS +: SNS_W]);

  status_read #(.ADDR_W(ADDR_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .stat1_val (stat1_val),
    .stat0_val (stat0_val),
    .rd_stat1  (rd_stat1),
    .rd_stat0  (rd_stat0),
    .rdata_q   (bus_rdata)
  );

  a_r9_sense_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat0 |=> bus_rdata[6:5] == $past(syn_vec[IX_SNS +: SNS_W]));
  a_r3_retrace_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat1 |=> bus_rdata[0] == $past(syn_vec[IX_HBL] | syn_vec[IX_VBL]));
  a_r2_reset_fc: assert property (@(posedge clk)
    !rst_n |=> fc_out == 2'b00);

endmodule

// File: tb/test_disp_status_regs.sv
module test_disp_status_regs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       hblank_in = 0, vblank_in = 0, vsync_in = 0;
  logic       pen_strobe = 0, pen_switch_open = 0;
  logic [1:0] sense_in = '0;
  logic [7:0] pix_attr = '0;
  logic [1:0] fc_out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  disp_status_regs i_disp_status_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .hblank_in(hblank_in), .vblank_in(vblank_in), .vsync_in(vsync_in),
    .pen_strobe(pen_strobe), .pen_switch_open(pen_switch_open),
    .sense_in(sense_in), .pix_attr(pix_attr), .fc_out(fc_out)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic io_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic io_read(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // Expected diagnostic pair worked out from bit positions per select
  function automatic logic [1:0] exp_diag(input logic [1:0] s, input logic [7:0] p);
    int hi, lo;
    hi = (s == 0) ? 2 : (s == 1) ? 5 : (s == 2) ? 3 : 7;
    lo = (s == 0) ? 0 : (s == 1) ? 4 : (s == 2) ? 1 : 6;
    return {p[hi], p[lo]};
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    check("R2 fc reset", {6'd0, fc_out}, 8'h00);
    io_read(3'd1, v);
    check("R2 stat0 idle ones", v & 8'h9F, 8'h9F);
    io_read(3'd0, v);
    check("R2 stat1 top ones / pen clear", v & 8'hC2, 8'hC0);
  endtask

  task automatic t_feature();
    io_write(3'd0, 8'hFE);
    check("R1 feat write 2", {6'd0, fc_out}, 8'h02);
    io_write(3'd0, 8'h01);
    check("R1 feat write 1", {6'd0, fc_out}, 8'h01);
    io_write(3'd2, 8'h03);
    check("R1 fc unchanged by other port", {6'd0, fc_out}, 8'h01);
    io_write(3'd2, 8'h00);
  endtask

  task automatic t_retrace();
    logic [7:0] v;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      hblank_in = k[0]; vblank_in = k[1];
      settle();
      io_read(3'd0, v);
      check("R3 retrace", {7'd0, v[0]}, {7'd0, k[0] | k[1]});
    end
    hblank_in = 0; vblank_in = 0;
  endtask

  task automatic t_switch_vsync();
    logic [7:0] v;
    @(negedge clk); pen_switch_open = 1; vsync_in = 0; settle();
    io_read(3'd0, v);
    check("R6 switch open", {6'd0, v[3:2]}, 8'h01);
    @(negedge clk); pen_switch_open = 0; vsync_in = 1; settle();
    io_read(3'd0, v);
    check("R7 vsync high", {6'd0, v[3:2]}, 8'h02);
    @(negedge clk); vsync_in = 0; settle();
  endtask

  task automatic t_pen();
    logic [7:0] v;
    @(negedge clk); pen_strobe = 1; settle();
    io_read(3'd0, v);
    check("R4 pen edge sets", {7'd0, v[1]}, 8'h01);
    @(negedge clk); pen_strobe = 0; settle();
    io_read(3'd0, v);
    check("R4 pen holds after strobe low", {7'd0, v[1]}, 8'h01);
    io_write(3'd3, 8'h00);
    io_read(3'd0, v);
    check("R4 clear port", {7'd0, v[1]}, 8'h00);
    io_write(3'd4, 8'h00);
    io_read(3'd0, v);
    check("R4 set port", {7'd0, v[1]}, 8'h01);
    io_write(3'd3, 8'h00);
  endtask

  task automatic t_pen_race();
    logic [7:0] v;
    // Clear lands in the cycle the synchronized edge is detected
    @(negedge clk); pen_strobe = 1;
    @(negedge clk);
    @(negedge clk); bus_addr = 3'd3; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    io_read(3'd0, v);
    check("R5 edge beats same-cycle clear", {7'd0, v[1]}, 8'h01);
    @(negedge clk); pen_strobe = 0; settle();
    io_write(3'd3, 8'h00);
    // Clear one cycle after the edge wins
    @(negedge clk); pen_strobe = 1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); bus_addr = 3'd3; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    io_read(3'd0, v);
    check("R5 later clear wins", {7'd0, v[1]}, 8'h00);
    @(negedge clk); pen_strobe = 0; settle();
  endtask

  task automatic t_mux();
    logic [7:0] v;
    logic [7:0] pats [3] = '{8'hA5, 8'h3C, 8'h96};
    foreach (pats[p]) begin
      @(negedge clk); pix_attr = pats[p];
      for (int s = 0; s < 4; s++) begin
        io_write(3'd2, 8'(s << 4));
        settle();
        io_read(3'd0, v);
        check("R8 diag pair", {6'd0, v[5:4]}, {6'd0, exp_diag(2'(s), pats[p])});
      end
    end
    io_write(3'd2, 8'h00);
  endtask

  task automatic t_sense();
    logic [7:0] v;
    // Probe style: drive a feature line, read sense, repeat
    @(negedge clk); sense_in = 2'b01;
    io_write(3'd0, 8'h01);
    settle();
    io_read(3'd1, v);
    check("R9 sense low read", {6'd0, v[6:5]}, 8'h01);
    @(negedge clk); sense_in = 2'b10;
    io_write(3'd0, 8'h02);
    settle();
    io_read(3'd1, v);
    check("R9 sense fresh on next read", {6'd0, v[6:5]}, 8'h02);
    check("R1 fc during probe", {6'd0, fc_out}, 8'h02);
  endtask

  task automatic t_timing_unmapped();
    logic [7:0] v;
    // Input changed, read issued one cycle later: not yet synchronized
    @(negedge clk); sense_in = 2'b11; bus_addr = 3'd1;
    @(negedge clk); bus_rd = 1;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
    check("R10 two-flop delay", {6'd0, v[6:5]}, 8'h02);
    io_read(3'd1, v);
    check("R10 settled value", {6'd0, v[6:5]}, 8'h03);
    io_read(3'd5, v);
    check("R10 unmapped 5", v, 8'hFF);
    io_read(3'd7, v);
    check("R10 unmapped 7", v, 8'hFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_feature();
    t_retrace();
    t_switch_vsync();
    t_pen();
    t_pen_race();
    t_mux();
    t_sense();
    t_timing_unmapped();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule